// File: doc/BRIEF.md
# Table-Programmed Character Readout Sequencer

This block paces the drawing of text characters on a vector display. A 4-bit state register walks through a short program stored in two lookup tables that share one address, the present state. The first table gives, for every state, a jump target, a code that picks one status input, and a flag that says whether the state branches at all. The second table gives three active-low strobes for that state: beam enable, dot-counter advance and character-counter advance.

On each rising clock edge the register either counts up by one or loads the jump target. In a state whose flag is set, the register always loads the target. In a state whose flag is clear, the picked status input decides: high counts up, low loads the target. The status inputs report the start of a readout, the last dot of a character, the end of a text line, and two character-address landmarks. Both tables are parameters, so the same block can run a different drawing program.

The register is cleared and held at zero whenever the power-good input or the display-enable input is low. It is also brought out as a port, so a trace of visited states can be compared against a model.

Top module: `readout_seq`

## Requirements
- R1: While `pwr_up_i` is low, `state_o` is 0, asynchronously and regardless of every other input.
- R2: While `disp_en_i` is low, `state_o` is 0, asynchronously and regardless of every other input.
- R3: When bit 0 of the present state's control word is 1, the next clock edge loads control bits 7:4 into the state, whatever the status inputs are.
- R4: When bit 0 is 0 and the status input chosen by control bits 3:1 is 1, the next clock edge adds one to the state, wrapping from 15 to 0.
- R5: When bit 0 is 0 and the chosen status input is 0, the next clock edge loads control bits 7:4 into the state.
- R6: Select codes map as follows: 0 picks `ro_start_i`, 2 picks `chr_at_11_i`, 3 picks `eoc_n_i`, 4 picks `eol_i` and 5 picks `chr_at_63_i`.
- R7: Select codes 1, 6 and 7 read a constant 1, so a branching state with one of these codes always counts up.
- R8: `{chr_clk_n_o, dot_clk_n_o, beam_on_n_o}` equals the 3-bit strobe-table entry of the present state, in the same cycle.
- R9: In the default program, state 0 drives all three strobes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock, rising edge |
| pwr_up_i | input | 1 | Power good; low holds the state at 0 |
| disp_en_i | input | 1 | Display enable; low holds the state at 0 |
| ro_start_i | input | 1 | High when a readout should begin |
| chr_at_11_i | input | 1 | High when the character address is 11 |
| eoc_n_i | input | 1 | Low on the last dot of a character |
| eol_i | input | 1 | High when the text line is finished |
| chr_at_63_i | input | 1 | High when the character address is 63 |
| beam_on_n_o | output | 1 | Beam enable strobe, active low |
| dot_clk_n_o | output | 1 | Dot-counter advance strobe, active low |
| chr_clk_n_o | output | 1 | Character-counter advance strobe, active low |
| state_o | output | 4 | Present state |

## Verification
A wrong state shows on `state_o` on the clock edge after the faulty transition. It also shows on the strobes in that same cycle whenever the wrong state has a different table entry. Once the state has diverged, the next branch reads a different control word, so the error keeps spreading through the trace instead of healing. For this reason the bench compares every cycle against a model. It runs two programs: the default one, and a second one that exercises the constant-high select codes and the wrap from 15 to 0.

// File: rtl/readout_seq_pkg.sv
package readout_seq_pkg;
    localparam int STATE_W    = 4;
    localparam int SEL_W      = 3;
    localparam int NUM_STATES = 2 ** STATE_W;
    localparam int NUM_COND   = 2 ** SEL_W;
    localparam int CTRL_W     = 1 + SEL_W + STATE_W;
    localparam int STRB_W     = 3;

    // Control word: [0] branch-free flag, [3:1] select, [7:4] target.
    // Entries listed from state 15 down to state 0.
    localparam logic [NUM_STATES*CTRL_W-1:0] DEF_CTRL =
        128'h0101_0101_0101_0101_0104_0A18_1146_0200;

    // Strobe word: [0] beam, [1] dot clock, [2] character clock.
    localparam logic [NUM_STATES*STRB_W-1:0] DEF_STRB =
        {{11{3'b111}}, 3'b011, 3'b111, 3'b101, 3'b110, 3'b111};

    typedef struct packed {
        logic [STATE_W-1:0] state;
    } ctr_t;
endpackage

// File: rtl/readout_lut.sv
module readout_lut #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    localparam int DEPTH = 2 ** ADDR_W,
    parameter logic [DEPTH*DATA_W-1:0] TABLE = '0
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [DATA_W-1:0] data_o
);
    logic [DATA_W-1:0] entries [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        assign entries[g] = TABLE[g*DATA_W +: DATA_W];
    end

    assign data_o = entries[addr_i];
endmodule

// File: rtl/readout_cond_mux.sv
module readout_cond_mux #(
    parameter int SEL_W = 3,
    localparam int NUM_COND = 2 ** SEL_W
) (
    input  logic [NUM_COND-1:0] cond_i,
    input  logic [SEL_W-1:0]    sel_i,
    input  logic                skip_i,
    output logic                count_o
);
    always_comb begin
        if (skip_i) count_o = 1'b0;
        else        count_o = cond_i[sel_i];
    end
endmodule

// File: rtl/readout_state_ctr.sv
module readout_state_ctr
    import readout_seq_pkg::*;
(
    input  logic               clk_i,
    input  logic               hold_n_i,
    input  logic               count_i,
    input  logic               skip_i,
    input  logic [STATE_W-1:0] target_i,
    output logic [STATE_W-1:0] state_o
);
    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (count_i) ctr_d.state = ctr_q.state + 1'b1;
        else         ctr_d.state = target_i;
    end

    always_ff @(posedge clk_i or negedge hold_n_i) begin
        if (!hold_n_i) ctr_q <= '0;
        else           ctr_q <= ctr_d;
    end

    assign state_o = ctr_q.state;

    AST_SKIP_LOADS: assert property (@(posedge clk_i) disable iff (!hold_n_i)
        skip_i |=> ctr_q.state == $past(target_i)); // R3
    AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!hold_n_i)
        (!skip_i && count_i) |=> ctr_q.state == STATE_W'($past(ctr_q.state) + 1'b1)); // R4
    AST_DECIDE_LOAD: assert property (@(posedge clk_i) disable iff (!hold_n_i)
        (!skip_i && !count_i) |=> ctr_q.state == $past(target_i)); // R5
    AST_HELD_ZERO: assert property (@(posedge clk_i)
        !hold_n_i |-> ctr_q.state == '0); // R1
endmodule

// File: rtl/readout_seq.sv
module readout_seq
    import readout_seq_pkg::*;
#(
    parameter logic [NUM_STATES*CTRL_W-1:0] CTRL_TABLE = DEF_CTRL,
    parameter logic [NUM_STATES*STRB_W-1:0] STRB_TABLE = DEF_STRB
) (
    input  logic               clk_i,
    input  logic               pwr_up_i,
    input  logic               disp_en_i,
    input  logic               ro_start_i,
    input  logic               chr_at_11_i,
    input  logic               eoc_n_i,
    input  logic               eol_i,
    input  logic               chr_at_63_i,
    output logic               beam_on_n_o,
    output logic               dot_clk_n_o,
    output logic               chr_clk_n_o,
    output logic [STATE_W-1:0] state_o
);
    logic                hold_n;
    logic [CTRL_W-1:0]   ctrl;
    logic [STRB_W-1:0]   strb;
    logic [NUM_COND-1:0] cond;
    logic                count;
    logic [STATE_W-1:0]  state;

    assign hold_n = pwr_up_i & disp_en_i;

    always_comb begin
        cond    = '1;
        cond[0] = ro_start_i;
        cond[2] = chr_at_11_i;
        cond[3] = eoc_n_i;
        cond[4] = eol_i;
        cond[5] = chr_at_63_i;
    end

    readout_lut #(.ADDR_W(STATE_W), .DATA_W(CTRL_W), .TABLE(CTRL_TABLE)) ctrl_lut_i (
        .addr_i (state),
        .data_o (ctrl)
    );

    readout_lut #(.ADDR_W(STATE_W), .DATA_W(STRB_W), .TABLE(STRB_TABLE)) strb_lut_i (
        .addr_i (state),
        .data_o (strb)
    );

    readout_cond_mux #(.SEL_W(SEL_W)) cond_mux_i (
        .cond_i  (cond),
        .sel_i   (ctrl[SEL_W:1]),
        .skip_i  (ctrl[0]),
        .count_o (count)
    );

    readout_state_ctr state_ctr_i (
        .clk_i    (clk_i),
        .hold_n_i (hold_n),
        .count_i  (count),
        .skip_i   (ctrl[0]),
        .target_i (ctrl[CTRL_W-1 -: STATE_W]),
        .state_o  (state)
    );

    assign beam_on_n_o = strb[0];
    assign dot_clk_n_o = strb[1];
    assign chr_clk_n_o = strb[2];
    assign state_o     = state;

    AST_CONST_SEL_COUNTS: assert property (@(posedge clk_i) disable iff (!hold_n)
        (!ctrl[0] && (ctrl[3:1] == 3'd1 || ctrl[3:1] >= 3'd6))
        |=> state == STATE_W'($past(state) + 1'b1)); // R7
    AST_DISABLE_HOLDS: assert property (@(posedge clk_i)
        !disp_en_i |-> state == '0); // R2
endmodule

// File: tb/readout_seq_tb_top.sv
module readout_seq_tb_top;
    localparam logic [127:0] P_CTRL = 128'h0101_0101_0101_0101_0104_0A18_1146_0200;
    localparam logic [47:0]  P_STRB = {{11{3'b111}}, 3'b011, 3'b111, 3'b101, 3'b110, 3'b111};
    localparam logic [127:0] A_CTRL = 128'h0E01_0101_0101_0101_0101_0101_01F1_0E0C;
    localparam logic [47:0]  A_STRB = {8{3'b001, 3'b110}};
    localparam int N_CYC = 4000;

    logic clk = 1'b0;
    logic pwr = 1'b0, disp = 1'b0;
    logic start = 1'b0, at11 = 1'b0, eoc_n = 1'b1, eol = 1'b0, at63 = 1'b0;
    logic bm0, dc0, cc0, bm1, dc1, cc1;
    logic [3:0] st0, st1;
    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    readout_seq dut_i (
        .clk_i(clk), .pwr_up_i(pwr), .disp_en_i(disp), .ro_start_i(start),
        .chr_at_11_i(at11), .eoc_n_i(eoc_n), .eol_i(eol), .chr_at_63_i(at63),
        .beam_on_n_o(bm0), .dot_clk_n_o(dc0), .chr_clk_n_o(cc0), .state_o(st0));

    readout_seq #(.CTRL_TABLE(A_CTRL), .STRB_TABLE(A_STRB)) alt_i (
        .clk_i(clk), .pwr_up_i(pwr), .disp_en_i(disp), .ro_start_i(start),
        .chr_at_11_i(at11), .eoc_n_i(eoc_n), .eol_i(eol), .chr_at_63_i(at63),
        .beam_on_n_o(bm1), .dot_clk_n_o(dc1), .chr_clk_n_o(cc1), .state_o(st1));

    // Condition vector per R6 and R7.
    function automatic logic [7:0] cvec();
        return {1'b1, 1'b1, at63, eol, eoc_n, at11, 1'b1, start};
    endfunction

    function automatic logic [3:0] model_next(logic [7:0] w, logic [3:0] s, logic [7:0] cv);
        if (w[0]) return w[7:4];                 // R3
        if (cv[w[3:1]]) return s + 4'd1;         // R4, wraps
        return w[7:4];                           // R5
    endfunction

    function automatic string rule_tag(logic [7:0] w, logic [7:0] cv);
        if (!pwr) return "R1";
        if (!disp) return "R2";
        if (w[0]) return "R3";
        if (w[3:1] == 3'd1 || w[3:1] >= 3'd6) return "R7";
        return cv[w[3:1]] ? "R6 R4" : "R6 R5";
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    initial begin
        logic [3:0] e0 = 0, e1 = 0, n0, n1;
        string t0, t1;
        void'($urandom(32'd2718));
        // Reset state with power low (R1) and default idle strobes (R9).
        #5;
        check("R1", {4'd0, st0}, 8'd0);
        check("R9", {5'd0, cc0, dc0, bm0}, 8'h07);
        @(negedge clk);
        pwr = 1'b1;
        #1 check("R2", {4'd0, st0}, 8'd0);
        @(negedge clk);
        check("R2", {4'd0, st1}, 8'd0);
        disp = 1'b1;
        for (int c = 0; c < N_CYC; c++) begin
            // Directed phases then random.
            if (c < 20) begin
                start = (c >= 3); eoc_n = (c % 4 != 3); eol = 1'b0; at11 = 1'b0; at63 = 1'b0;
                pwr = 1'b1; disp = 1'b1;
            end else begin
                pwr   = ($urandom % 25) != 0;
                disp  = ($urandom % 15) != 0;
                start = $urandom % 2;
                at11  = $urandom % 2;
                eoc_n = ($urandom % 4) != 0;
                eol   = ($urandom % 3) == 0;
                at63  = $urandom % 2;
            end
            #1;
            if (!(pwr && disp)) begin
                e0 = 0; e1 = 0;
                check(pwr ? "R2" : "R1", {4'd0, st0}, 8'd0);
                check(pwr ? "R2" : "R1", {4'd0, st1}, 8'd0);
                n0 = 0; n1 = 0;
            end else begin
                n0 = model_next(P_CTRL[e0*8 +: 8], e0, cvec());
                n1 = model_next(A_CTRL[e1*8 +: 8], e1, cvec());
            end
            t0 = rule_tag(P_CTRL[e0*8 +: 8], cvec());
            t1 = rule_tag(A_CTRL[e1*8 +: 8], cvec());
            @(negedge clk);
            e0 = n0; e1 = n1;
            check(t0, {4'd0, st0}, {4'd0, e0});
            check(t1, {4'd0, st1}, {4'd0, e1});
            check("R8", {5'd0, cc0, dc0, bm0}, {5'd0, P_STRB[e0*3 +: 3]});
            check("R8", {5'd0, cc1, dc1, bm1}, {5'd0, A_STRB[e1*3 +: 3]});
            if (e0 == 0) check("R9", {5'd0, cc0, dc0, bm0}, 8'h07);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * (N_CYC + 1000));
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule